// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the controller that steps a multi-cycle processor datapath through the cycles of each instruction. It reads the 6-bit major opcode from the instruction register and the ALU zero flag. A 4-bit state register selects a fixed set of datapath strobes and multiplexer selects for every cycle. Different instruction classes take different numbers of cycles. Loads take five cycles, stores and register-register operations take four, conditional branches take three, and jumps take three.

The state register sits between two combinational blocks: next-state logic and an output decoder. Only the output decoder looks at the zero flag, and only to gate the program counter load in the branch state. The decode cycle has no other use for the ALU, so it adds the word-scaled offset to PC+4 and parks the branch target in the ALU output register. The branch cycle then compares the two source registers and commits that target when they are equal. An opcode outside the supported set sends decode straight back to fetch, so the instruction has no architectural effect.

State codes: Fetch=0, Decode=1, AddrCalc=2, MemRead=3, MemWriteback=4, MemWrite=5, Execute=6, ExecWriteback=7, BranchCmp=8, JumpSet=9.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the state goes to Fetch (0). After reset, Fetch drives `mem_read`=1, `ir_load`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=1 and `alu_op`=0.
- R2: A load (opcode 100011) visits states 0, 1, 2, 3, 4 and then returns to 0, taking five cycles.
- R3: A store (opcode 101011) visits states 0, 1, 2, 5 and then returns to 0, taking four cycles.
- R4: A register-register operation (opcode 000000) visits states 0, 1, 6, 7 and then returns to 0, taking four cycles.
- R5: A branch-if-equal (opcode 000100) visits states 0, 1, 8 and then returns to 0. In state 8, `pc_load` equals `zero` and `pc_src`=1 selects the stored target.
- R6: A jump (opcode 000010) visits states 0, 1, 9 and then returns to 0. In state 9, `pc_load`=1 and `pc_src`=2 selects the jump address.
- R7: Any other opcode goes from Decode straight back to Fetch. In that Decode cycle, `pc_load`, `reg_write`, `mem_write` and `ir_load` are all 0.
- R8: `pc_load` is 1 in states 0 and 9, equals `zero` in state 8, and is 0 in every other state. In state 0, `pc_src` is 0 (the incremented PC).
- R9: `reg_write` is 1 only in states 4 and 7. In state 4, `dst_sel`=0 (rt) and `wb_sel`=1 (memory data). In state 7, `dst_sel`=1 (rd) and `wb_sel`=0 (ALU result). `mem_write` is 1 only in state 5.
- R10: `alu_a_sel` is 0 (PC) in states 0 and 1, and 1 (register A) in states 2, 6 and 8. `alu_b_sel` is 1 (constant 4) in state 0, 3 (sign-extended immediate shifted left by two) in state 1, 2 (sign-extended immediate) in state 2, and 0 (register B) in states 6 and 8.
- R11: `alu_op` is 0 (add) in states 0, 1 and 2, 1 (subtract) in state 8, and 2 (use the funct field) in state 6.
- R12: `ir_load` is 1 only in state 0. `mem_read` is 1 only in states 0 and 3. `addr_sel`=1 (ALU output register) in states 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to Fetch, active high |
| opcode | input | 6 | Major opcode field from the instruction register |
| zero | input | 1 | ALU zero flag |
| state | output | 4 | Current state code |
| pc_load | output | 1 | Program counter write enable |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump address |
| ir_load | output | 1 | Instruction register write enable |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| reg_write | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 constant 4, 2 immediate, 3 immediate shifted left by two |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 funct field |

## Verification
The assertions assume that `opcode` stays stable from Decode until the instruction returns to Fetch, because the instruction register only changes in Fetch. They also assume that `zero` is meaningful only in the branch state. The bench keeps to this by setting the opcode and flag at a falling edge just before each instruction starts and holding them until Fetch is seen again. It runs every supported class, both outcomes of the branch, and several unsupported opcodes back to back.

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       zero,
  output logic [3:0] state,
  output logic       pc_load,
  output logic [1:0] pc_src,
  output logic       ir_load,
  output logic       mem_read,
  output logic       mem_write,
  output logic       addr_sel,
  output logic       reg_write,
  output logic       dst_sel,
  output logic       wb_sel,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op
);

  localparam logic [3:0] S_FETCH = 4'd0, S_DEC = 4'd1, S_ADDR = 4'd2, S_MRD = 4'd3,
                         S_MWB = 4'd4, S_MWR = 4'd5, S_EXE = 4'd6, S_XWB = 4'd7,
                         S_BR = 4'd8, S_JMP = 4'd9;

  localparam logic [5:0] OP_REG = 6'b000000, OP_LD = 6'b100011, OP_ST = 6'b101011,
                         OP_BEQ = 6'b000100, OP_JMP = 6'b000010;

  logic [3:0] cur_q, nxt;

  always_ff @(posedge clk) begin
    if (rst) cur_q <= S_FETCH;
    else     cur_q <= nxt;
  end

  assign state = cur_q;

  always_comb begin
    nxt = S_FETCH;
    case (cur_q)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        case (opcode)
          OP_LD, OP_ST: nxt = S_ADDR;
          OP_REG:       nxt = S_EXE;
          OP_BEQ:       nxt = S_BR;
          OP_JMP:       nxt = S_JMP;
          default:      nxt = S_FETCH;
        endcase
      end
      S_ADDR:  nxt = (opcode == OP_ST) ? S_MWR : S_MRD;
      S_MRD:   nxt = S_MWB;
      S_EXE:   nxt = S_XWB;
      default: nxt = S_FETCH;
    endcase
  end

  always_comb begin
    pc_load = 1'b0; pc_src = 2'd0; ir_load = 1'b0; mem_read = 1'b0;
    mem_write = 1'b0; addr_sel = 1'b0; reg_write = 1'b0; dst_sel = 1'b0;
    wb_sel = 1'b0; alu_a_sel = 1'b0; alu_b_sel = 2'd0; alu_op = 2'd0;
    case (cur_q)
      S_FETCH: begin
        mem_read = 1'b1; ir_load = 1'b1; alu_b_sel = 2'd1; pc_load = 1'b1;
      end
      S_DEC:  alu_b_sel = 2'd3;
      S_ADDR: begin alu_a_sel = 1'b1; alu_b_sel = 2'd2; end
      S_MRD:  begin mem_read = 1'b1; addr_sel = 1'b1; end
      S_MWB:  begin reg_write = 1'b1; wb_sel = 1'b1; end
      S_MWR:  begin mem_write = 1'b1; addr_sel = 1'b1; end
      S_EXE:  begin alu_a_sel = 1'b1; alu_op = 2'd2; end
      S_XWB:  begin reg_write = 1'b1; dst_sel = 1'b1; end
      S_BR:   begin alu_a_sel = 1'b1; alu_op = 2'd1; pc_src = 2'd1; pc_load = zero; end
      S_JMP:  begin pc_src = 2'd2; pc_load = 1'b1; end
      default: ;
    endcase
  end

  a_r2_load_path: assert property (@(posedge clk) disable iff (rst)
    (cur_q == S_ADDR && opcode == OP_LD) |=> (cur_q == S_MRD));
  a_r3_store_path: assert property (@(posedge clk) disable iff (rst)
    (cur_q == S_ADDR && opcode == OP_ST) |=> (cur_q == S_MWR));
  a_r5_branch_gate: assert property (@(posedge clk) disable iff (rst)
    (cur_q == S_BR) |-> (pc_load == zero));
  a_r7_unknown_back: assert property (@(posedge clk) disable iff (rst)
    (cur_q == S_DEC && opcode != OP_REG && opcode != OP_LD && opcode != OP_ST &&
     opcode != OP_BEQ && opcode != OP_JMP) |=> (cur_q == S_FETCH));
  a_r8_pc_only_legal: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (cur_q == S_FETCH || cur_q == S_JMP || cur_q == S_BR));
  a_r9_regwrite_states: assert property (@(posedge clk) disable iff (rst)
    reg_write |-> (cur_q == S_MWB || cur_q == S_XWB));
  a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_write, mem_write}) <= 1);
  a_r12_fetch_follows: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (cur_q == S_DEC));

endmodule

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb_top;
  logic clk = 1'b0, rst = 1'b1, zero = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state;
  logic pc_load, ir_load, mem_read, mem_write, addr_sel, reg_write, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mc_seq_ctrl dut_i (.clk(clk), .rst(rst), .opcode(opcode), .zero(zero), .state(state),
    .pc_load(pc_load), .pc_src(pc_src), .ir_load(ir_load), .mem_read(mem_read),
    .mem_write(mem_write), .addr_sel(addr_sel), .reg_write(reg_write), .dst_sel(dst_sel),
    .wb_sel(wb_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op));

  function automatic logic [14:0] expect_out(input logic [3:0] s, input logic z);
    logic pl, irl, mr, mw, as, rw, ds, ws, aa;
    logic [1:0] ps, bs, op;
    {pl, irl, mr, mw, as, rw, ds, ws, aa} = '0; ps = 0; bs = 0; op = 0;
    case (s)
      4'd0: begin pl = 1; irl = 1; mr = 1; bs = 1; end
      4'd1: bs = 3;
      4'd2: begin aa = 1; bs = 2; end
      4'd3: begin mr = 1; as = 1; end
      4'd4: begin rw = 1; ws = 1; end
      4'd5: begin mw = 1; as = 1; end
      4'd6: begin aa = 1; op = 2; end
      4'd7: begin rw = 1; ds = 1; end
      4'd8: begin aa = 1; op = 1; ps = 1; pl = z; end
      4'd9: begin pl = 1; ps = 2; end
      default: ;
    endcase
    return {pl, ps, irl, mr, mw, as, rw, ds, ws, aa, bs, op};
  endfunction

  function automatic logic [14:0] actual_out();
    return {pc_load, pc_src, ir_load, mem_read, mem_write, addr_sel, reg_write,
            dst_sel, wb_sel, alu_a_sel, alu_b_sel, alu_op};
  endfunction

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // run one instruction: seq holds state codes, first in the low nibble
  task automatic run_instr(input string tag, input logic [5:0] op, input logic z,
                           input int n, input logic [23:0] seq);
    opcode = op; zero = z;
    for (int i = 0; i < n; i++) begin
      logic [3:0] es;
      es = seq[4*i +: 4];
      check(tag, {11'd0, state}, {11'd0, es});
      check("R8 R9 R10 R11 R12 outputs", actual_out(), expect_out(es, z));
      @(negedge clk);
    end
    check({tag, " return to fetch"}, {11'd0, state}, 15'd0);
  endtask

  task automatic t_reset();
    check("R1 reset state", {11'd0, state}, 15'd0);
    check("R1 fetch outputs", actual_out(), expect_out(4'd0, 1'b0));
  endtask

  task automatic t_load();   run_instr("R2 load",  6'b100011, 1'b0, 5, 24'h43210); endtask
  task automatic t_store();  run_instr("R3 store", 6'b101011, 1'b1, 4, 24'h5210);  endtask
  task automatic t_reg();    run_instr("R4 reg op", 6'b000000, 1'b1, 4, 24'h7610); endtask
  task automatic t_br_taken();  run_instr("R5 branch taken", 6'b000100, 1'b1, 3, 24'h810); endtask
  task automatic t_br_not();    run_instr("R5 branch not taken", 6'b000100, 1'b0, 3, 24'h810); endtask
  task automatic t_jump();   run_instr("R6 jump", 6'b000010, 1'b0, 3, 24'h910); endtask

  task automatic t_unknown(input logic [5:0] op);
    opcode = op; zero = 1'b1;
    @(negedge clk);
    check("R7 decode state", {11'd0, state}, 15'd1);
    check("R7 no side effects", {11'd0, pc_load, reg_write, mem_write, ir_load}, 15'd0);
    @(negedge clk);
    check("R7 back to fetch", {11'd0, state}, 15'd0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_store();
    t_reg();
    t_br_taken();
    t_br_not();
    t_jump();
    t_unknown(6'b001000);
    t_unknown(6'b111111);
    t_unknown(6'b000101);
    t_load();
    t_jump();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule